// File: doc/BRIEF.md
# One-Wire Search Triplet Step

This unit carries out a single branch step of the one-wire device-identity search. Once started, it asks a downstream bit-slot engine for two read slots. The first read returns the identity bit that every responding device drives, and the second returns that bit's complement. The unit then chooses a branch direction and sends it back on the bus as a write slot, so that devices whose identity disagrees with the branch drop out of the search.

When both reads return 0, devices on both branches are present. In that case the unit follows a preferred direction supplied by the caller when the step is started. When only one of the two reads is 1, the branch is forced to the identity bit. When both reads are 1, no device answered, so the unit writes nothing and reports a result that tells the caller to restart the search. The caller owns the 64-step loop and the record of last discrepancies. This unit only reports a three-bit result per step.

The downstream port is a uniform "touch" request. `slotTxBit` gives the level released after the low pulse, and `slotRxBit` returns the sampled level. A read slot is therefore a touch with `slotTxBit` = 1.

Top module: `triplet_step`

## Requirements
- R1: After an accepted start, the first two slots requested are read slots (`slotTxBit` = 1). The first slot's sample is the identity bit, reported in `stepStatus[0]`. The second slot's sample is the complement bit, reported in `stepStatus[1]`.
- R2: If both samples are 1, `stepStatus` is 3'b011 and no third slot is requested.
- R3: If both samples are 0, the direction taken is the preferred direction. `stepStatus` is 3'b100 when that direction is 1 and 3'b000 when it is 0.
- R4: If exactly one sample is 1, the direction taken equals the identity bit. `stepStatus` is 3'b101 when the identity bit is 1 and 3'b010 when it is 0.
- R5: In every non-error case, exactly one third slot is requested, and its `slotTxBit` equals the direction taken (`stepStatus[2]`).
- R6: `stepDone` is high for exactly one cycle per step. It rises after the last slot of the step is acknowledged (the third slot, or the second slot in the error case). `stepStatus` is valid from that cycle until the next step captures a sample.
- R7: `prefDir` is sampled in the cycle the start is accepted. Changes to it during the step have no effect.
- R8: A `stepGo` that arrives while a step is in progress is ignored. It causes no extra slots and no extra `stepDone`.
- R9: After reset, `slotReq` and `stepDone` are 0 and `stepStatus` is 3'b000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| stepGo | input | 1 | Start a step (accepted when idle) |
| prefDir | input | 1 | Preferred branch when both branches are populated |
| stepDone | output | 1 | One-cycle pulse when the step ends |
| stepStatus | output | 3 | {direction taken, complement bit, identity bit} |
| slotReq | output | 1 | Slot wanted; held until acknowledged |
| slotTxBit | output | 1 | Level to release in the slot (1 for reads) |
| slotAck | input | 1 | One-cycle pulse: requested slot finished |
| slotRxBit | input | 1 | Bus level sampled in the slot, valid with slotAck |

## Verification
The checker assumes that the slot engine raises `slotAck` only while `slotReq` is high and only for one cycle, and that `slotRxBit` is meaningful only in that cycle. Its per-step slot counter relies on this to tell read slots from the write slot. The bench's engine model follows the same rules. It waits for a request and holds the acknowledge for a single cycle after a programmable latency. It drives `slotRxBit` from a per-slot script and otherwise drives it to the opposite level, so that a stray capture would show up.

// File: rtl/tstep_pkg.sv
package tstep_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ_ID,
    ST_READ_CMP,
    ST_DECIDE,
    ST_WRITE_DIR,
    ST_FINISH
  } stepState_t;

  typedef struct packed {
    logic loadDir;
    logic capId;
    logic capCmp;
  } stepCtl_t;

  localparam int STATUS_W = 3;

endpackage

// File: rtl/tstep_path.sv
module tstep_path
  import tstep_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  stepCtl_t            ctl,
  input  logic                prefDir,
  input  logic                slotRxBit,
  output logic                errFlag,
  output logic                chosenDir,
  output logic [STATUS_W-1:0] status
);

  logic prefQ;
  logic idQ;
  logic cmpQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prefQ <= 1'b0;
      idQ   <= 1'b0;
      cmpQ  <= 1'b0;
    end else begin
      if (ctl.loadDir) prefQ <= prefDir;
      if (ctl.capId)   idQ   <= slotRxBit;
      if (ctl.capCmp)  cmpQ  <= slotRxBit;
    end
  end

  // Only one branch populated: follow the identity bit; otherwise the caller's choice.
  always_comb begin
    errFlag   = idQ & cmpQ;
    chosenDir = (idQ ^ cmpQ) ? idQ : prefQ;
    status    = {(chosenDir & ~errFlag), cmpQ, idQ};
  end

endmodule

// File: rtl/tstep_ctrl.sv
module tstep_ctrl
  import tstep_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     stepGo,
  input  logic     slotAck,
  input  logic     errFlag,
  input  logic     chosenDir,
  output logic     slotReq,
  output logic     slotTxBit,
  output logic     stepDone,
  output logic     busy,
  output stepCtl_t ctl
);

  stepState_t state, stateNext;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    ctl       = '0;
    slotReq   = 1'b0;
    slotTxBit = 1'b1;
    stepDone  = 1'b0;
    busy      = (state != ST_IDLE);
    unique case (state)
      ST_IDLE: begin
        if (stepGo) begin
          ctl.loadDir = 1'b1;
          stateNext   = ST_READ_ID;
        end
      end
      ST_READ_ID: begin
        slotReq = 1'b1;
        if (slotAck) begin
          ctl.capId = 1'b1;
          stateNext = ST_READ_CMP;
        end
      end
      ST_READ_CMP: begin
        slotReq = 1'b1;
        if (slotAck) begin
          ctl.capCmp = 1'b1;
          stateNext  = ST_DECIDE;
        end
      end
      ST_DECIDE: begin
        stateNext = errFlag ? ST_FINISH : ST_WRITE_DIR;
      end
      ST_WRITE_DIR: begin
        slotReq   = 1'b1;
        slotTxBit = chosenDir;
        if (slotAck) stateNext = ST_FINISH;
      end
      ST_FINISH: begin
        stepDone  = 1'b1;
        stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/triplet_step.sv
module triplet_step
  import tstep_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       stepGo,
  input  logic       prefDir,
  output logic       stepDone,
  output logic [2:0] stepStatus,
  output logic       slotReq,
  output logic       slotTxBit,
  input  logic       slotAck,
  input  logic       slotRxBit
);

  stepCtl_t ctl;
  logic     errFlag;
  logic     chosenDir;
  logic     busy;

  tstep_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .stepGo    (stepGo),
    .slotAck   (slotAck),
    .errFlag   (errFlag),
    .chosenDir (chosenDir),
    .slotReq   (slotReq),
    .slotTxBit (slotTxBit),
    .stepDone  (stepDone),
    .busy      (busy),
    .ctl       (ctl)
  );

  tstep_path u_path (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .prefDir   (prefDir),
    .slotRxBit (slotRxBit),
    .errFlag   (errFlag),
    .chosenDir (chosenDir),
    .status    (stepStatus)
  );

endmodule

// File: rtl/tstep_checker.sv
module tstep_checker (
  input logic       clk,
  input logic       rstN,
  input logic       stepGo,
  input logic       busy,
  input logic       slotReq,
  input logic       slotTxBit,
  input logic       slotAck,
  input logic       stepDone,
  input logic [2:0] stepStatus
);

  logic [1:0] ackCount;

  always_ff @(posedge clk) begin
    if (!rstN)                 ackCount <= 2'd0;
    else if (stepGo && !busy)  ackCount <= 2'd0;
    else if (slotAck && slotReq && ackCount != 2'd3) ackCount <= ackCount + 2'd1;
  end

  // R6: the completion strobe never lasts two cycles
  p_done_single_r6: assert property (@(posedge clk) disable iff (!rstN)
    stepDone |=> !stepDone);

  // R1: the first two slots of a step are reads
  p_reads_first_r1: assert property (@(posedge clk) disable iff (!rstN)
    (slotReq && ackCount < 2'd2) |-> slotTxBit);

  // R2: no-response ends after exactly two slots
  p_error_two_slots_r2: assert property (@(posedge clk) disable iff (!rstN)
    (stepDone && stepStatus[1:0] == 2'b11) |-> (ackCount == 2'd2 && stepStatus[2] == 1'b0));

  // R5: a non-error step ends after its third slot
  p_write_three_slots_r5: assert property (@(posedge clk) disable iff (!rstN)
    (stepDone && stepStatus[1:0] != 2'b11) |-> ackCount == 2'd3);

  // R5: the written level matches the reported direction
  p_write_matches_status_r5: assert property (@(posedge clk) disable iff (!rstN)
    (slotReq && ackCount == 2'd2) |-> slotTxBit == stepStatus[2]);

  // R8: no slot is requested while a finished step awaits a new start
  p_no_req_at_done_r8: assert property (@(posedge clk) disable iff (!rstN)
    stepDone |=> !slotReq);

endmodule

bind triplet_step tstep_checker u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .stepGo     (stepGo),
  .busy       (busy),
  .slotReq    (slotReq),
  .slotTxBit  (slotTxBit),
  .slotAck    (slotAck),
  .stepDone   (stepDone),
  .stepStatus (stepStatus)
);

// File: tb/test_triplet_step.sv
`timescale 1ns/1ps
module test_triplet_step;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       stepGo = 1'b0;
  logic       prefDir = 1'b0;
  logic       stepDone;
  logic [2:0] stepStatus;
  logic       slotReq;
  logic       slotTxBit;
  logic       slotAck = 1'b0;
  logic       slotRxBit = 1'b0;

  int checks = 0;
  int errors = 0;

  logic resp [0:3];
  logic txLog [0:7];
  int   slotCnt = 0;
  int   doneCnt = 0;
  int   slotLat = 1;
  bit   finished = 0;

  triplet_step i_triplet_step (
    .clk        (clk),
    .rstN       (rstN),
    .stepGo     (stepGo),
    .prefDir    (prefDir),
    .stepDone   (stepDone),
    .stepStatus (stepStatus),
    .slotReq    (slotReq),
    .slotTxBit  (slotTxBit),
    .slotAck    (slotAck),
    .slotRxBit  (slotRxBit)
  );

  always #2 clk = ~clk;

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // slot engine model
  initial begin
    forever begin
      @(negedge clk);
      if (slotReq && rstN) begin
        for (int k = 0; k < slotLat; k++) @(negedge clk);
        if (slotCnt < 8) txLog[slotCnt] = slotTxBit;
        slotRxBit = (slotCnt < 4) ? resp[slotCnt] : 1'b0;
        slotAck = 1'b1;
        slotCnt++;
        @(negedge clk);
        slotAck = 1'b0;
        slotRxBit = ~slotRxBit;
      end
    end
  end

  // completion pulse monitor
  initial begin
    forever begin
      @(negedge clk);
      if (stepDone) doneCnt++;
    end
  end

  task automatic runStep(input string req, input logic pref, input logic idB, input logic cmpB,
                         input logic [2:0] expStatus, input int expSlots, input bit flipPref,
                         input bit extraGo);
    int waitCyc;
    resp[0] = idB; resp[1] = cmpB; resp[2] = 1'b0; resp[3] = 1'b0;
    slotCnt = 0;
    doneCnt = 0;
    @(negedge clk);
    stepGo = 1'b1;
    prefDir = pref;
    @(negedge clk);
    stepGo = 1'b0;
    if (flipPref) prefDir = ~pref;
    waitCyc = 0;
    while (!stepDone && waitCyc < 300) begin
      if (extraGo && waitCyc == 3) stepGo = 1'b1;
      else stepGo = 1'b0;
      @(negedge clk);
      waitCyc++;
    end
    stepGo = 1'b0;
    check({req, " done seen"}, {7'd0, stepDone}, 8'd1);
    check({req, " status"}, {5'd0, stepStatus}, {5'd0, expStatus});
    check({req, " slot count"}, slotCnt[7:0], expSlots[7:0]);
    check({"R1 read slot 0 ", req}, {7'd0, txLog[0]}, 8'd1);
    check({"R1 read slot 1 ", req}, {7'd0, txLog[1]}, 8'd1);
    if (expSlots == 3)
      check({"R5 write level ", req}, {7'd0, txLog[2]}, {7'd0, expStatus[2]});
    @(negedge clk);
    check({"R6 pulse width ", req}, {7'd0, stepDone}, 8'd0);
    check({"R6 status held ", req}, {5'd0, stepStatus}, {5'd0, expStatus});
    for (int k = 0; k < 20; k++) @(negedge clk);
    check({"R8 no extra done ", req}, doneCnt[7:0], 8'd1);
    check({"R8 no extra slot ", req}, slotCnt[7:0], expSlots[7:0]);
  endtask

  task automatic testReset();
    @(negedge clk);
    check("R9 req after reset", {7'd0, slotReq}, 8'd0);
    check("R9 done after reset", {7'd0, stepDone}, 8'd0);
    check("R9 status after reset", {5'd0, stepStatus}, 8'd0);
  endtask

  initial begin
    for (int k = 0; k < 200000; k++) begin
      @(posedge clk);
      if (finished) break;
    end
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    testReset();
    rstN = 1'b1;
    testReset();
    slotLat = 1;
    runStep("R2 no response", 1'b1, 1'b1, 1'b1, 3'b011, 2, 0, 0);
    runStep("R3 conflict pref1", 1'b1, 1'b0, 1'b0, 3'b100, 3, 0, 0);
    runStep("R3 conflict pref0", 1'b0, 1'b0, 1'b0, 3'b000, 3, 0, 0);
    runStep("R4 id one", 1'b0, 1'b1, 1'b0, 3'b101, 3, 0, 0);
    runStep("R4 id zero", 1'b1, 1'b0, 1'b1, 3'b010, 3, 0, 0);
    slotLat = 0;
    runStep("R7 pref held 1", 1'b1, 1'b0, 1'b0, 3'b100, 3, 1, 0);
    slotLat = 5;
    runStep("R7 pref held 0", 1'b0, 1'b0, 1'b0, 3'b000, 3, 1, 0);
    runStep("R8 busy start", 1'b0, 1'b1, 1'b0, 3'b101, 3, 0, 1);
    slotLat = 2;
    runStep("R8 busy start err", 1'b0, 1'b1, 1'b1, 3'b011, 2, 0, 1);
    runStep("R6 after error", 1'b1, 1'b0, 1'b1, 3'b010, 3, 0, 0);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule